// File: doc/BRIEF.md
# Wormhole Packet Switch Node

This block is one switching node of an on-chip packet network arranged as a tree. Traffic is carried as packets of 32-bit flits, each with a 2-bit kind tag: a head flit that carries the destination address, any number of body flits, and a closing trailer flit that holds a checksum. The node has four downward ports, each serving one quarter of the node's subtree, and one upward port that leads toward the rest of the network. Every port has a receive side and a send side, and every link uses valid/ready flow control.

A flit that arrives is queued in a FIFO at its receive side. When a head flit reaches the front of that FIFO, a fixed address rule picks its send port. Each send port uses round-robin order to pick among the heads that want it. The winner keeps that port until its trailer has gone through. Flits stream through as soon as the path is held, so a packet can be spread across several nodes at the same time. Each send port has a small buffer of its own. Each receive side also tracks a running checksum of the packet. A wrong trailer value gives a one-cycle error pulse on that port, and the packet is still delivered unchanged.

Top module: `wh_switch`

## Requirements
- R1: A flit is a 2-bit kind plus 32 data bits. The kind codes are 00 idle, 01 head, 10 body and 11 trailer. The destination address is bits [31:24] of the head flit, and flits leave the node with kind and data unchanged.
- R2: The subtree of the node is the set of addresses whose bits [7:SUB_BITS] equal those of NODE_ADDR. With the defaults (0x40, 4) this is 0x40 to 0x4F. A head inside the subtree goes to the down port given by address bits [3:2]. Any other head goes to port 4, the up port.
- R3: A head flit accepted at one clock edge is offered at its send port two edges later, provided that port is free. Flits that are already accepted move on before the trailer has been received.
- R4: Once a packet holds a send port, no flit from any other receive port reaches that send port until the trailer of the holding packet has been sent. Each packet leaves as one contiguous run.
- R5: Heads that contend for a free send port are served in round-robin order. The search starts at the receive port just after the last port that was granted on that send port, and it starts at port 0 after reset.
- R6: A flit moves only when valid and ready are both high. A send port whose ready is low holds its flit and data stable. When the send buffer and the receive FIFO fill, in_ready of the sending port drops and no flit is lost or reordered.
- R7: The expected trailer value is the XOR of the head flit data and all body flit data. On a mismatch, csum_err of the receive port is high for exactly the one cycle after the trailer is accepted. The packet is forwarded unchanged either way.
- R8: Idle flits (kind 00) that are offered with valid high are accepted and dropped. They never appear at any send port.
- R9: After reset, no send port is valid, every receive port is ready and no error is flagged.
- R10: Packets from different receive ports to different send ports move in the same cycles, without waiting for each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_DOWN+1 | Flit offered on each receive port |
| in_ready | output | NUM_DOWN+1 | Receive FIFO has room |
| in_type | input | (NUM_DOWN+1)x2 | Flit kind for each receive port |
| in_data | input | (NUM_DOWN+1)x32 | Flit data for each receive port |
| out_valid | output | NUM_DOWN+1 | Flit available on each send port |
| out_ready | input | NUM_DOWN+1 | Downstream accepts the send flit |
| out_type | output | (NUM_DOWN+1)x2 | Flit kind for each send port |
| out_data | output | (NUM_DOWN+1)x32 | Flit data for each send port |
| csum_err | output | NUM_DOWN+1 | One-cycle checksum mismatch pulse per receive port |

## Verification
The hardest case to reach from the ports is a real contention pattern. Several heads must reach the front of their FIFOs in the same cycle, and the round-robin pointer of the contested port must sit at a known position. The bench gets there by launching all receive-port drivers on the same clock edge. It also fixes the order of the scenarios, so each pointer position follows from the grants made earlier: a later round then shows a higher-numbered port winning ahead of port 0. Backpressure that reaches all the way back to in_ready is produced by holding a send port stalled until its buffer and the receive FIFO behind it are both full.

// File: rtl/wh_pkg.sv
package wh_pkg;
    localparam int FLIT_DW = 32;

    typedef enum logic [1:0] {
        FT_IDLE = 2'b00,
        FT_HEAD = 2'b01,
        FT_BODY = 2'b10,
        FT_TAIL = 2'b11
    } ftype_e;

    typedef struct packed {
        ftype_e              kind;
        logic [FLIT_DW-1:0]  data;
    } flit_t;
endpackage

// File: rtl/wh_fifo.sv
module wh_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr_en, rd_en;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr = step(st_q.wr);
        if (rd_en) st_d.rd = step(st_q.rd);
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr] <= din;
    end
endmodule

// File: rtl/wh_route.sv
module wh_route #(
    parameter int         NUM_DOWN  = 4,
    parameter logic [7:0] NODE_ADDR = 8'h40,
    parameter int         SUB_BITS  = 4
) (
    input  logic [7:0]        dest,
    output logic [NUM_DOWN:0] sel
);
    localparam int SEL_W = $clog2(NUM_DOWN);

    always_comb begin
        sel = '0;
        if ((dest >> SUB_BITS) == (NODE_ADDR >> SUB_BITS))
            sel[dest[SUB_BITS-1 -: SEL_W]] = 1'b1;
        else
            sel[NUM_DOWN] = 1'b1;
    end
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] gnt,
    output logic         any
);
    localparam int PW = $clog2(N);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[PW'((int'(st_q.ptr) + k) % N)]) begin
                gnt[PW'((int'(st_q.ptr) + k) % N)] = 1'b1;
                any = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < N; j++) begin
            if (take && gnt[j]) st_d.ptr = (j == N - 1) ? '0 : PW'(j + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wh_csum.sv
module wh_csum
    import wh_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  logic [1:0]  kind,
    input  logic [31:0] data,
    output logic        err
);
    typedef struct packed {
        logic [31:0] acc;
        logic        err;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (fire) begin
            case (ftype_e'(kind))
                FT_HEAD: st_d.acc = data;
                FT_BODY: st_d.acc = st_q.acc ^ data;
                FT_TAIL: st_d.err = (st_q.acc != data);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/wh_switch.sv
module wh_switch
    import wh_pkg::*;
#(
    parameter int         NUM_DOWN  = 4,
    parameter int         IN_DEPTH  = 4,
    parameter int         OUT_DEPTH = 2,
    parameter logic [7:0] NODE_ADDR = 8'h40,
    parameter int         SUB_BITS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_DOWN:0]        in_valid,
    output logic [NUM_DOWN:0]        in_ready,
    input  logic [NUM_DOWN:0][1:0]   in_type,
    input  logic [NUM_DOWN:0][31:0]  in_data,
    output logic [NUM_DOWN:0]        out_valid,
    input  logic [NUM_DOWN:0]        out_ready,
    output logic [NUM_DOWN:0][1:0]   out_type,
    output logic [NUM_DOWN:0][31:0]  out_data,
    output logic [NUM_DOWN:0]        csum_err
);
    localparam int NP = NUM_DOWN + 1;
    localparam int IW = $clog2(NP);
    localparam int FW = $bits(flit_t);

    typedef struct packed {
        logic [NP-1:0]         busy;
        logic [NP-1:0][IW-1:0] owner;
    } sw_st_t;

    sw_st_t st_d, st_q;

    flit_t                 ifront [NP];
    flit_t                 obuf_din [NP];
    logic [FW-1:0]         ifront_raw [NP];
    logic [FW-1:0]         obuf_raw [NP];
    logic [NP-1:0]         iempty, ifull, ipop, ipush;
    logic [NP-1:0][NP-1:0] route;
    logic [NP-1:0][NP-1:0] req;
    logic [NP-1:0][NP-1:0] gnt;
    logic [NP-1:0]         any, take, move, tail_move, ofull, oempty;
    logic [NP-1:0][IW-1:0] src;
    logic [NP-1:0]         owns;
    logic [NP-1:0]         busy_q;
    logic [NP-1:0][IW-1:0] owner_q;

    assign busy_q  = st_q.busy;
    assign owner_q = st_q.owner;

    for (genvar i = 0; i < NP; i++) begin : g_in
        assign in_ready[i] = !ifull[i];
        assign ipush[i]    = in_valid[i] && !ifull[i] && (in_type[i] != FT_IDLE);
        assign ifront[i]   = flit_t'(ifront_raw[i]);

        wh_fifo #(.WIDTH(FW), .DEPTH(IN_DEPTH)) u_ifq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (ipush[i]),
            .din   ({in_type[i], in_data[i]}),
            .full  (ifull[i]),
            .pop   (ipop[i]),
            .dout  (ifront_raw[i]),
            .empty (iempty[i])
        );

        wh_csum u_cs (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (ipush[i]),
            .kind  (in_type[i]),
            .data  (in_data[i]),
            .err   (csum_err[i])
        );

        wh_route #(.NUM_DOWN(NUM_DOWN), .NODE_ADDR(NODE_ADDR), .SUB_BITS(SUB_BITS)) u_rt (
            .dest (ifront[i].data[31:24]),
            .sel  (route[i])
        );
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        wh_rr_arb #(.N(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[o]),
            .take  (take[o]),
            .gnt   (gnt[o]),
            .any   (any[o])
        );

        wh_fifo #(.WIDTH(FW), .DEPTH(OUT_DEPTH)) u_obuf (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (move[o]),
            .din   (obuf_din[o]),
            .full  (ofull[o]),
            .pop   (out_valid[o] && out_ready[o]),
            .dout  (obuf_raw[o]),
            .empty (oempty[o])
        );

        assign out_valid[o] = !oempty[o];
        assign out_type[o]  = obuf_raw[o][FW-1 -: 2];
        assign out_data[o]  = obuf_raw[o][31:0];
    end

    // Requests: a waiting head asks only for its routed port, and never while its input holds a lock.
    always_comb begin
        owns = '0;
        for (int o = 0; o < NP; o++) begin
            if (st_q.busy[o]) owns[st_q.owner[o]] = 1'b1;
        end
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req[o][i] = !iempty[i] && (ifront[i].kind == FT_HEAD) && !owns[i] && route[i][o];
            end
        end
    end

    // Path selection, flit movement and lock next state.
    always_comb begin
        logic [IW-1:0] gidx;
        st_d = st_q;
        ipop = '0;
        for (int o = 0; o < NP; o++) begin
            gidx = '0;
            for (int j = 0; j < NP; j++) begin
                if (gnt[o][j]) gidx = IW'(j);
            end
            take[o]      = !st_q.busy[o] && any[o];
            src[o]       = st_q.busy[o] ? st_q.owner[o] : gidx;
            move[o]      = (st_q.busy[o] || any[o]) && !iempty[src[o]] && !ofull[o];
            obuf_din[o]  = ifront[src[o]];
            tail_move[o] = move[o] && (ifront[src[o]].kind == FT_TAIL);
            if (move[o]) ipop[src[o]] = 1'b1;
            if (tail_move[o]) begin
                st_d.busy[o] = 1'b0;
            end else if (take[o]) begin
                st_d.busy[o]  = 1'b1;
                st_d.owner[o] = gidx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wh_switch_chk.sv
module wh_switch_chk #(
    parameter int NUM_DOWN = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_DOWN:0]                   out_valid,
    input logic [NUM_DOWN:0]                   out_ready,
    input logic [NUM_DOWN:0][1:0]              out_type,
    input logic [NUM_DOWN:0][31:0]             out_data,
    input logic [NUM_DOWN:0]                   csum_err,
    input logic [NUM_DOWN:0]                   busy,
    input logic [NUM_DOWN:0][$clog2(NUM_DOWN+1)-1:0] owner,
    input logic [NUM_DOWN:0]                   tail_move
);
    localparam int NP = NUM_DOWN + 1;
    localparam int IW = $clog2(NP);

    logic [NP-1:0] held_by [NP];

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                held_by[i][o] = busy[o] && (owner[o] == IW'(i));
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_o
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o]) && $stable(out_type[o])); // R6
        AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            busy[o] && !tail_move[o] |=> busy[o] && $stable(owner[o])); // R4
        AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            tail_move[o] |=> !busy[o]); // R4
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
        AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            csum_err[i] |=> !csum_err[i]); // R7
        AST_ONE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(held_by[i]) <= 1); // R4
    end
endmodule

bind wh_switch wh_switch_chk #(.NUM_DOWN(NUM_DOWN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_type  (out_type),
    .out_data  (out_data),
    .csum_err  (csum_err),
    .busy      (busy_q),
    .owner     (owner_q),
    .tail_move (tail_move)
);

// File: tb/tb_wh_switch.sv
module tb_wh_switch;
    localparam int NP = 5;
    localparam int MX = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        in_valid = '0;
    logic [NP-1:0]        in_ready;
    logic [NP-1:0][1:0]   in_type = '0;
    logic [NP-1:0][31:0]  in_data = '0;
    logic [NP-1:0]        out_valid;
    logic [NP-1:0]        out_ready = '1;
    logic [NP-1:0][1:0]   out_type;
    logic [NP-1:0][31:0]  out_data;
    logic [NP-1:0]        csum_err;

    wh_switch dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_data(out_data),
        .csum_err(csum_err)
    );

    always #5 clk = ~clk;

    logic [33:0] stim  [NP][MX];
    logic [33:0] exp_f [NP][MX];
    logic [33:0] cap   [NP][MX];
    int stim_n [NP];
    int exp_n  [NP];
    int cap_n  [NP];
    int first_cyc [NP];
    int head_cyc  [NP];
    int tail_cyc  [NP];
    int err_cnt   [NP];
    int err_cyc   [NP];
    int cyc = 0;
    int seq = 0;
    bit clr = 1'b0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (clr) begin
            for (int p = 0; p < NP; p++) begin
                cap_n[p] = 0; err_cnt[p] = 0; first_cyc[p] = -1; err_cyc[p] = -1;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (in_valid[p] && in_ready[p]) begin
                    if (in_type[p] == 2'b01) head_cyc[p] = cyc;
                    if (in_type[p] == 2'b11) tail_cyc[p] = cyc;
                end
                if (out_valid[p] && out_ready[p]) begin
                    if (cap_n[p] == 0) first_cyc[p] = cyc;
                    if (cap_n[p] < MX) cap[p][cap_n[p]] = {out_type[p], out_data[p]};
                    cap_n[p]++;
                end
                if (csum_err[p]) begin
                    err_cnt[p]++; err_cyc[p] = cyc;
                end
            end
        end
        cyc++;
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push_stim(input int p, input logic [1:0] t, input logic [31:0] d);
        stim[p][stim_n[p]] = {t, d}; stim_n[p]++;
    endtask

    task automatic push_exp(input int o, input logic [1:0] t, input logic [31:0] d);
        exp_f[o][exp_n[o]] = {t, d}; exp_n[o]++;
    endtask

    // Builds one packet on input src, expected on output o; bad corrupts the trailer.
    task automatic add_pkt(input int src, input int o, input logic [7:0] dest, input int nbody, input bit bad);
        logic [31:0] cs, w;
        w = {dest, 8'(src), 16'(seq)};
        cs = w;
        push_stim(src, 2'b01, w); push_exp(o, 2'b01, w);
        for (int k = 0; k < nbody; k++) begin
            w = {8'hB0, 8'(seq), 8'(src), 8'(k)};
            cs = cs ^ w;
            push_stim(src, 2'b10, w); push_exp(o, 2'b10, w);
        end
        if (bad) cs = cs ^ 32'h0000_0100;
        push_stim(src, 2'b11, cs); push_exp(o, 2'b11, cs);
        seq++;
    endtask

    task automatic drive(input int p);
        for (int k = 0; k < stim_n[p]; k++) begin
            @(negedge clk);
            in_valid[p] = 1'b1;
            in_type[p]  = stim[p][k][33:32];
            in_data[p]  = stim[p][k][31:0];
            while (!in_ready[p]) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic drive_all();
        fork
            drive(0); drive(1); drive(2); drive(3); drive(4);
        join
    endtask

    task automatic fresh();
        repeat (4) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int p = 0; p < NP; p++) begin
            stim_n[p] = 0; exp_n[p] = 0;
        end
    endtask

    task automatic compare_out(input string req);
        repeat (20) @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            chk(cap_n[o] == exp_n[o], req, $sformatf("flit count port %0d", o), cap_n[o], exp_n[o]);
            for (int k = 0; k < exp_n[o] && k < cap_n[o]; k++)
                chk(cap[o][k] == exp_f[o][k], {req, " R1"}, $sformatf("flit %0d port %0d", k, o),
                    cap[o][k], exp_f[o][k]);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R9", "out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R9", "in_ready after reset", in_ready, 5'h1f);
        chk(csum_err == '0, "R9", "csum_err after reset", csum_err, 0);
    endtask

    task automatic t_stream_and_idle();
        logic [31:0] h, b;
        fresh();
        h = 32'h4900_0102; b = 32'hDEAD_0001;
        push_stim(0, 2'b01, h); push_stim(0, 2'b10, b);
        push_exp(2, 2'b01, h); push_exp(2, 2'b10, b); push_exp(2, 2'b11, h ^ b);
        drive(0);
        repeat (6) @(negedge clk);
        chk(cap_n[2] == 2, "R3", "flits out before trailer sent", cap_n[2], 2);
        chk(first_cyc[2] - head_cyc[0] == 2, "R3", "head latency", first_cyc[2] - head_cyc[0], 2);
        stim_n[0] = 0;
        push_stim(0, 2'b00, 32'hFFFF_FFFF); push_stim(0, 2'b00, 32'h1234_5678);
        push_stim(0, 2'b11, h ^ b);
        drive(0);
        compare_out("R8");
        chk(err_cnt[0] == 0, "R7", "no error on good packet", err_cnt[0], 0);
    endtask

    task automatic t_routes_parallel();
        fresh();
        add_pkt(0, 0, 8'h40, 3, 1'b0);
        add_pkt(1, 1, 8'h44, 3, 1'b0);
        add_pkt(2, 2, 8'h4B, 3, 1'b0);
        add_pkt(3, 3, 8'h4C, 3, 1'b0);
        add_pkt(4, 4, 8'h90, 3, 1'b0);
        drive_all();
        compare_out("R2");
        for (int o = 1; o < NP; o++)
            chk(first_cyc[o] == first_cyc[0], "R10", $sformatf("port %0d starts with port 0", o),
                first_cyc[o], first_cyc[0]);
    endtask

    task automatic t_lock_rr();
        fresh();
        add_pkt(0, 3, 8'h4C, 2, 1'b0);
        add_pkt(1, 3, 8'h4D, 3, 1'b0);
        add_pkt(2, 3, 8'h4F, 1, 1'b0);
        drive_all();
        compare_out("R4");
        fresh();
        add_pkt(4, 3, 8'h4E, 2, 1'b0);
        add_pkt(0, 3, 8'h4C, 2, 1'b0);
        drive_all();
        compare_out("R5");
    endtask

    task automatic t_backpressure();
        fresh();
        add_pkt(0, 2, 8'h48, 10, 1'b0);
        out_ready[2] = 1'b0;
        fork
            drive(0);
            begin
                repeat (20) @(negedge clk);
                chk(in_ready[0] == 1'b0, "R6", "in_ready low when full", in_ready[0], 0);
                chk(out_valid[2] == 1'b1 && cap_n[2] == 0, "R6", "stalled output held", cap_n[2], 0);
                for (int k = 0; k < 30; k++) begin
                    out_ready[2] = k[0];
                    @(negedge clk);
                end
                out_ready[2] = 1'b1;
            end
        join
        compare_out("R6");
    endtask

    task automatic t_checksum();
        fresh();
        add_pkt(1, 4, 8'h50, 3, 1'b0);
        add_pkt(2, 4, 8'h3F, 2, 1'b1);
        drive_all();
        compare_out("R7");
        chk(err_cnt[1] == 0, "R7", "good packet no pulse", err_cnt[1], 0);
        chk(err_cnt[2] == 1, "R7", "bad packet one pulse", err_cnt[2], 1);
        chk(err_cyc[2] == tail_cyc[2] + 1, "R7", "pulse cycle", err_cyc[2], tail_cyc[2] + 1);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            stim_n[p] = 0; exp_n[p] = 0; cap_n[p] = 0; err_cnt[p] = 0;
            first_cyc[p] = -1; head_cyc[p] = -1; tail_cyc[p] = -1; err_cyc[p] = -1;
        end
        t_reset();
        t_stream_and_idle();
        t_routes_parallel();
        t_lock_rr();
        t_backpressure();
        t_checksum();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule